// File: doc/BRIEF.md
# Receive Alarm Change Interrupt Controller

This block takes a receive red-alarm level (loss of frame) that a framer has already qualified. It turns changes of that level into a processor interrupt. The level is brought into the local clock domain through a synchroniser. Every transition of the alarm is detected, in either direction, and latched into a sticky change flag. The present alarm level is shown next to the flag as a read-only bit.

The interrupt output is high when three things hold together: the sticky flag is set, the per-alarm enable is set, and the block-wide enable is set. The output comes from a register. A control bit sets how software clears the flag. In one mode a read of the status register clears it. In the other mode software must write a one to the flag's bit position.

Software reaches four byte-wide registers through a plain strobe port. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address. There is no data stream here, so no valid/ready handshake is used and there is no back-pressure.

Top module: `almirq_ctrl`

## Requirements
- R1: The per-alarm enable is bit 2 of the register at address 3. While it is 0, irq_o stays low whatever the sticky flag does. Setting it while the flag is set raises irq_o one cycle after the write edge.
- R2: The block enable is bit 1 of the register at address 1. While it is 0, irq_o stays low.
- R3: The sticky change flag is bit 2 of the status register at address 2. It becomes 1 three clock edges after alarm_in changes, for a rise and for a fall alike.
- R4: The live alarm level is bit 6 of the status register. It follows alarm_in two clock edges after the input changes. Writes do not affect it.
- R5: When bit 0 of the control register at address 0 is 1 (clear-on-read), a read of address 2 returns the value before clearing and clears the flag at that edge. In this mode, writes to address 2 have no effect on the flag.
- R6: When control bit 0 is 0 (write-to-clear), writing address 2 with bit 2 set to 1 clears the flag, and writing a 0 there leaves it unchanged. In this mode, reads never clear the flag.
- R7: An alarm change that sets the flag at the same edge as a clearing read or write wins, and the flag stays 1.
- R8: irq_o is the registered AND of the flag and both enables. It rises one edge after the flag sets and falls one edge after the flag clears.
- R9: After reset, every register is 0 and irq_o is low. Bits with no defined function read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_in | input | 1 | Qualified receive red-alarm level, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read side effect) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Counting from the edge at which alarm_in is first sampled, the live bit is due after the second edge, the sticky flag after the third, and irq_o after the fourth. A register write or a clearing read shows in read data right after its own edge, and in irq_o one edge later. The bench drives every input on the falling clock edge and compares outputs shortly after, before the next rising edge. Each expected value in the vector table and in the directed tests is placed at the row whose preceding rising edges match these counts. The collision tests put the clearing access exactly in the cycle of the third edge.

// File: rtl/almirq_pkg.sv
package almirq_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADR_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] ADR_BLKEN = 2'd1;
  localparam logic [REG_AW-1:0] ADR_STAT  = 2'd2;
  localparam logic [REG_AW-1:0] ADR_AEN   = 2'd3;

  localparam int B_ROR   = 0;  // control: clear-on-read select
  localparam int B_BLKEN = 1;  // block enable
  localparam int B_CHG   = 2;  // sticky change flag / its enable
  localparam int B_LIVE  = 6;  // live alarm level
endpackage

// File: rtl/almirq_sync.sv
module almirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic change_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o  = chain[STAGES-1];
  assign change_o = chain[STAGES-1] ^ prev;

  // R3: a detected change is followed by the edge memory taking the new level
  assert_edge_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    change_o |=> (prev != $past(prev)));
endmodule

// File: rtl/almirq_regs.sv
module almirq_regs
  import almirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              live_i,
  input  logic              change_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              sticky_o,
  output logic              aen_o,
  output logic              ben_o
);
  logic ror_q, ben_q, aen_q, sticky_q;
  logic stat_sel, clr_wr, clr_rd, clr_any;

  assign stat_sel = (addr_i == ADR_STAT);
  assign clr_wr   = wr_i && stat_sel && wdata_i[B_CHG] && !ror_q;
  assign clr_rd   = rd_i && stat_sel && ror_q;
  assign clr_any  = clr_wr || clr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ror_q <= 1'b0;
      ben_q <= 1'b0;
      aen_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADR_CTRL:  ror_q <= wdata_i[B_ROR];
        ADR_BLKEN: ben_q <= wdata_i[B_BLKEN];
        ADR_AEN:   aen_q <= wdata_i[B_CHG];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else        sticky_q <= change_i | (sticky_q & ~clr_any);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL:  rdata_o[B_ROR]   = ror_q;
      ADR_BLKEN: rdata_o[B_BLKEN] = ben_q;
      ADR_STAT: begin
        rdata_o[B_CHG]  = sticky_q;
        rdata_o[B_LIVE] = live_i;
      end
      default:   rdata_o[B_CHG]   = aen_q;
    endcase
  end

  assign sticky_o = sticky_q;
  assign aen_o    = aen_q;
  assign ben_o    = ben_q;

  assert_change_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    change_i |=> sticky_q);
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (change_i && (wr_i || rd_i) && stat_sel) |=> sticky_q);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ror_q && rd_i && stat_sel && !change_i) |=> !sticky_q);
  assert_hold_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ror_q && sticky_q && !(wr_i && stat_sel && wdata_i[B_CHG])) |=> sticky_q);
endmodule

// File: rtl/almirq_irq.sv
module almirq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic sticky_i,
  input  logic aen_i,
  input  logic ben_i,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= sticky_i & aen_i & ben_i;
  end

  assert_alarm_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !aen_i |=> !irq_o);
  assert_block_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ben_i |=> !irq_o);
  assert_quiet_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sticky_i |=> !irq_o);
endmodule

// File: rtl/almirq_ctrl.sv
module almirq_ctrl
  import almirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq_o
);
  logic live, change, sticky, aen, ben;

  almirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(alarm_in),
    .level_o(live), .change_o(change)
  );

  almirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .live_i(live),
    .change_i(change), .rdata_o(reg_rdata), .sticky_o(sticky),
    .aen_o(aen), .ben_o(ben)
  );

  almirq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sticky_i(sticky), .aen_i(aen),
    .ben_i(ben), .irq_o(irq_o)
  );
endmodule

// File: tb/test_almirq_ctrl.sv
`timescale 1ns/1ps
module test_almirq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_in = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  almirq_ctrl i_almirq_ctrl (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic       alarm, wr, rd, chk;
    logic [1:0] addr;
    logic [7:0] wdata, exp_rd;
    logic       exp_irq;
  } vec_t;

  // Rows 0-12: write-to-clear (R6); 13-19: clear-on-read with collision (R5, R7);
  // 20-26: block enable off (R2). Live bit (R4), flag (R3), irq (R8) throughout.
  localparam vec_t TBL [27] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'd1,8'h02,8'h00,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,2'd3,8'h04,8'h00,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd1,8'h00,8'h02,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd3,8'h00,8'h04,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h40,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h44,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,2'd2,8'h00,8'h00,1'b1},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h44,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,2'd2,8'h04,8'h00,1'b1},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h40,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,2'd0,8'h01,8'h00,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd0,8'h00,8'h01,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd2,8'h00,8'h40,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd2,8'h00,8'h00,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd2,8'h00,8'h04,1'b1},
    '{1'b0,1'b0,1'b1,1'b1,2'd2,8'h00,8'h00,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,2'd1,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h44,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,2'd2,8'h00,8'h40,1'b0}
  };

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic a, logic w, logic r, logic [1:0] ad, logic [7:0] d);
    alarm_in = a; reg_wr = w; reg_rd = r; reg_addr = ad; reg_wdata = d;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd_chk(logic a, logic [1:0] ad, logic [7:0] exp, string tag);
    drive(a, 1'b0, 1'b1, ad, 8'h00); #1;
    check(tag, reg_rdata, exp);
    step();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    check("R9 irq after reset", {7'd0, irq_o}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0]; #0.1;
      check("R9 register after reset", reg_rdata, 8'h00);
    end
    rst_n = 1'b1;
    step();

    for (int k = 0; k < 27; k++) begin
      drive(TBL[k].alarm, TBL[k].wr, TBL[k].rd, TBL[k].addr, TBL[k].wdata);
      #1;
      if (TBL[k].chk) check($sformatf("R3/R4/R5/R6 row %0d rdata", k), reg_rdata, TBL[k].exp_rd);
      check($sformatf("R8/R2 row %0d irq", k), {7'd0, irq_o}, {7'd0, TBL[k].exp_irq});
      step();
    end

    // R5: in clear-on-read mode a status write does not clear the flag
    drive(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    step(); step(); step();
    drive(1'b0, 1'b1, 1'b0, 2'd2, 8'h04); step();
    rd_chk(1'b0, 2'd2, 8'h04, "R5 write ignored in clear-on-read");
    rd_chk(1'b0, 2'd2, 8'h00, "R5 read cleared flag");

    // R1: alarm enable off gates irq; enabling it raises irq next edge
    drive(1'b0, 1'b1, 1'b0, 2'd3, 8'h00); step();
    drive(1'b0, 1'b1, 1'b0, 2'd1, 8'h02); step();
    drive(1'b0, 1'b1, 1'b0, 2'd0, 8'h00); step();
    drive(1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
    for (int i = 0; i < 6; i++) begin
      #1; check("R1 irq held low by alarm enable", {7'd0, irq_o}, 8'h00);
      step();
    end
    rd_chk(1'b1, 2'd2, 8'h44, "R6 read does not clear in write-to-clear");
    drive(1'b1, 1'b1, 1'b0, 2'd3, 8'h04); step();
    drive(1'b1, 1'b0, 1'b0, 2'd0, 8'h00); step();
    #1; check("R1 irq after enabling", {7'd0, irq_o}, 8'h01);

    // R7: clearing write in the same cycle the flag is set
    drive(1'b1, 1'b1, 1'b0, 2'd2, 8'h04); step();
    drive(1'b0, 1'b0, 1'b0, 2'd0, 8'h00); step(); step();
    drive(1'b0, 1'b1, 1'b0, 2'd2, 8'h04); step();
    rd_chk(1'b0, 2'd2, 8'h04, "R7 set wins over write clear");

    // R9/R4: undefined bits and read-only live bit
    drive(1'b0, 1'b1, 1'b0, 2'd3, 8'hFF); step();
    rd_chk(1'b0, 2'd3, 8'h04, "R9 undefined bits addr3");
    drive(1'b0, 1'b1, 1'b0, 2'd0, 8'hFE); step();
    rd_chk(1'b0, 2'd0, 8'h00, "R9 undefined bits addr0");
    drive(1'b0, 1'b1, 1'b0, 2'd2, 8'h40); step();
    rd_chk(1'b0, 2'd2, 8'h04, "R4 live bit not writable");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule